// File: doc/BRIEF.md
# Robust-Code Encryption Round Checker

This block watches one full encryption round of a 128-bit block cipher datapath (the AES round with substitution, row rotation, column mixing and key addition) and flags any disagreement between what the round was given and what it produced. It takes the round input state, the round key and the round output state. From the input and key it forms a 32-bit predicted signature, one byte per state column. From the output it forms a 32-bit folded signature by XORing the four bytes of each column together. Both signatures are cubed in GF(2^32) and the two cubes are compared. The cubing step makes whether an error is caught depend on the data as well as on the error pattern, so an error that escapes one block is unlikely to escape the next.

The predictor never mixes columns. The column-mixing coefficients of a column add up to one, and the four copies of the substitution constant cancel. So the XOR of one output column is just the linear part of the substitution affine map, applied to the XOR of four field inverses, plus the XOR of the four key bytes of that column. The four inverses come from the diagonal that the row rotation brings into the column.

A sample is taken on any clock edge where `inValid` is high, and samples may arrive back to back. The verdict appears a fixed number of cycles later as a one-cycle `chkValid` pulse, with `errFlag` alongside it. A parameter adds a register stage after the two cubing networks, which splits the long multiply path at the cost of one cycle of latency.

Top module: `rcc_round_checker`

## Requirements
- R1: While `rstN` is low, and from the edge after reset is asserted, `chkValid` and `errFlag` are 0. They stay 0 until a sample has passed through the pipeline.
- R2: If `roundOut` is the correct full round of `roundIn` under `roundKey`, the verdict has `errFlag` = 0. State byte (row i, column j) of every 128-bit port sits at bits [127-8(4j+i) -: 8], and output column j depends on input bytes (i, (j+i) mod 4).
- R3: A sample taken on an edge with `inValid` = 1 yields `chkValid` = 1 for exactly one cycle. The pulse follows the edge after LAT = 2 + PIPE_CUBE clock edges, counting the sampling edge as the first.
- R4: Flipping any single bit of `roundOut` away from the correct round result gives `errFlag` = 1 in that sample's verdict.
- R5: Flipping a single bit of `roundKey` away from the key that produced `roundOut` gives `errFlag` = 1.
- R6: Flipping a single bit of `roundIn` away from the state that produced `roundOut` gives `errFlag` = 1.
- R7: A zero input byte is treated as having inverse zero. A correct round whose input contains zero bytes, including an all-zero input, key and output, gives `errFlag` = 0.
- R8: `errFlag` is 1 only in cycles where `chkValid` is 1.
- R9: Samples taken on consecutive edges each get their own verdict, in order, and an error in one sample does not change the verdict of its neighbours.
- R10: An error that flips the same bit position in two output bytes of the same column cancels in the fold and is not flagged (`errFlag` = 0).
- R11: With `inValid` held low, changes on `roundIn`, `roundKey` and `roundOut` produce no `chkValid` pulse and no `errFlag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample the three state buses on this edge |
| roundIn | input | 128 | State entering the round |
| roundKey | input | 128 | Round key added at the end of the round |
| roundOut | input | 128 | State produced by the round under test |
| chkValid | output | 1 | One-cycle pulse marking a verdict |
| errFlag | output | 1 | Cubed signatures differ for the sample being reported |

## Verification
The bench builds the checker with PIPE_CUBE = 1, so the verdict arrives three edges after sampling. This puts both register stages between sampling and reporting, which lets back-to-back streams show whether a verdict leaks into its neighbours while up to three samples are in flight at once. Correct rounds come from a reference round model inside the bench. Its S-box is found by brute-force inverse search, and the faults it injects are single-bit flips and a column-cancelling pair.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  localparam int BYTE_W  = 8;
  localparam int ROWS    = 4;
  localparam int COLS    = 4;
  localparam int STATE_W = BYTE_W * ROWS * COLS;
  localparam int SIG_W   = BYTE_W * COLS;

  // x^8 + x^4 + x^3 + x + 1 without the leading term
  localparam logic [BYTE_W-1:0] BYTE_POLY_TAIL = 8'h1B;
  // x^32 + x^7 + x^3 + x^2 + 1 without the leading term
  localparam logic [SIG_W-1:0]  SIG_POLY_TAIL  = 32'h0000_008D;

  typedef logic [STATE_W-1:0] state_t;
  typedef logic [SIG_W-1:0]   sig_t;
  typedef logic [BYTE_W-1:0]  byte_t;

  typedef struct packed {
    logic sigLoad;
    logic cubeLoad;
    logic flagLoad;
  } strobe_t;

  // byte of row r, column c in column-major order, first byte at the MSB
  function automatic byte_t stByte(input state_t s, input int r, input int c);
    return s[STATE_W-1-BYTE_W*(ROWS*c+r) -: BYTE_W];
  endfunction

  function automatic byte_t gf8Mul(input byte_t a, input byte_t b);
    byte_t acc, sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < BYTE_W; k++) begin
      if (b[k]) acc ^= sh;
      sh = {sh[BYTE_W-2:0], 1'b0} ^ (sh[BYTE_W-1] ? BYTE_POLY_TAIL : '0);
    end
    return acc;
  endfunction

  // a^(2^8-2) as the product of a^2, a^4, ..., a^128; zero maps to zero
  function automatic byte_t gf8Inv(input byte_t a);
    byte_t sq, acc;
    sq  = a;
    acc = 8'h01;
    for (int k = 1; k < BYTE_W; k++) begin
      sq  = gf8Mul(sq, sq);
      acc = gf8Mul(acc, sq);
    end
    return acc;
  endfunction

  function automatic byte_t rotl1(input byte_t b);
    return {b[BYTE_W-2:0], b[BYTE_W-1]};
  endfunction

  // linear part of the substitution affine map (constant dropped)
  function automatic byte_t affLin(input byte_t b);
    byte_t r1, r2, r3, r4;
    r1 = rotl1(b);
    r2 = rotl1(r1);
    r3 = rotl1(r2);
    r4 = rotl1(r3);
    return b ^ r1 ^ r2 ^ r3 ^ r4;
  endfunction

  function automatic sig_t gf32Mul(input sig_t a, input sig_t b);
    sig_t acc, sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < SIG_W; k++) begin
      if (b[k]) acc ^= sh;
      sh = {sh[SIG_W-2:0], 1'b0} ^ (sh[SIG_W-1] ? SIG_POLY_TAIL : '0);
    end
    return acc;
  endfunction

  // squaring is linear: spread bits to even positions, then reduce
  function automatic sig_t gf32Sq(input sig_t a);
    logic [2*SIG_W-1:0] wide;
    logic [SIG_W:0]     polyFull;
    wide     = '0;
    polyFull = {1'b1, SIG_POLY_TAIL};
    for (int k = 0; k < SIG_W; k++) wide[2*k] = a[k];
    for (int k = 2*SIG_W-1; k >= SIG_W; k--) begin
      if (wide[k]) wide[k-SIG_W +: SIG_W+1] ^= polyFull;
    end
    return wide[SIG_W-1:0];
  endfunction

endpackage

// File: rtl/rcc_predictor.sv
module rcc_predictor
  import rcc_pkg::*;
(
  input  state_t roundIn,
  input  state_t roundKey,
  output sig_t   predSig
);

  for (genvar j = 0; j < COLS; j++) begin : g_col
    byte_t invSum;
    byte_t keySum;

    always_comb begin
      invSum = '0;
      keySum = '0;
      for (int i = 0; i < ROWS; i++) begin
        invSum ^= gf8Inv(stByte(roundIn, i, (j + i) % COLS));
        keySum ^= stByte(roundKey, i, j);
      end
    end

    assign predSig[SIG_W-1-BYTE_W*j -: BYTE_W] = affLin(invSum) ^ keySum;
  end

endmodule

// File: rtl/rcc_compressor.sv
module rcc_compressor
  import rcc_pkg::*;
(
  input  state_t roundOut,
  output sig_t   compSig
);

  for (genvar j = 0; j < COLS; j++) begin : g_col
    byte_t colSum;

    always_comb begin
      colSum = '0;
      for (int i = 0; i < ROWS; i++) colSum ^= stByte(roundOut, i, j);
    end

    assign compSig[SIG_W-1-BYTE_W*j -: BYTE_W] = colSum;
  end

endmodule

// File: rtl/rcc_cube.sv
module rcc_cube
  import rcc_pkg::*;
(
  input  sig_t base,
  output sig_t cube
);

  sig_t squared;

  assign squared = gf32Sq(base);
  assign cube    = gf32Mul(squared, base);

endmodule

// File: rtl/rcc_ctrl.sv
module rcc_ctrl
  import rcc_pkg::*;
#(
  parameter int LAT = 3
)(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t strobe,
  output logic    chkValid
);

  logic [LAT-1:0] stageVld;

  if (LAT > 1) begin : g_shift
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageVld <= '0;
      else       stageVld <= {stageVld[LAT-2:0], inValid};
    end
  end else begin : g_single
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageVld <= '0;
      else       stageVld <= inValid;
    end
  end

  always_comb begin
    strobe.sigLoad  = inValid;
    strobe.cubeLoad = stageVld[0];
    strobe.flagLoad = stageVld[LAT-2];
  end

  assign chkValid = stageVld[LAT-1];

endmodule

// File: rtl/rcc_datapath.sv
module rcc_datapath
  import rcc_pkg::*;
#(
  parameter int PIPE_CUBE = 1
)(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  state_t  roundIn,
  input  state_t  roundKey,
  input  state_t  roundOut,
  output logic    mismatch
);

  sig_t predComb, compComb;
  sig_t predReg, compReg;
  sig_t predCube, compCube;
  sig_t predCubeQ, compCubeQ;
  logic flagQ;

  rcc_predictor u_pred (
    .roundIn (roundIn),
    .roundKey(roundKey),
    .predSig (predComb)
  );

  rcc_compressor u_comp (
    .roundOut(roundOut),
    .compSig (compComb)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      predReg <= '0;
      compReg <= '0;
    end else if (strobe.sigLoad) begin
      predReg <= predComb;
      compReg <= compComb;
    end
  end

  rcc_cube u_cubeP (
    .base(predReg),
    .cube(predCube)
  );

  rcc_cube u_cubeC (
    .base(compReg),
    .cube(compCube)
  );

  if (PIPE_CUBE != 0) begin : g_cubeReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        predCubeQ <= '0;
        compCubeQ <= '0;
      end else if (strobe.cubeLoad) begin
        predCubeQ <= predCube;
        compCubeQ <= compCube;
      end
    end
  end else begin : g_cubeWire
    assign predCubeQ = predCube;
    assign compCubeQ = compCube;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                flagQ <= 1'b0;
    else if (strobe.flagLoad) flagQ <= (predCubeQ != compCubeQ);
    else                      flagQ <= 1'b0;
  end

  assign mismatch = flagQ;

endmodule

// File: rtl/rcc_round_checker.sv
module rcc_round_checker
  import rcc_pkg::*;
#(
  parameter int PIPE_CUBE = 1
)(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [127:0] roundIn,
  input  logic [127:0] roundKey,
  input  logic [127:0] roundOut,
  output logic         chkValid,
  output logic         errFlag
);

  localparam int LAT = 2 + ((PIPE_CUBE != 0) ? 1 : 0);

  strobe_t strobe;

  rcc_ctrl #(.LAT(LAT)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .chkValid(chkValid)
  );

  rcc_datapath #(.PIPE_CUBE(PIPE_CUBE)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .roundIn (roundIn),
    .roundKey(roundKey),
    .roundOut(roundOut),
    .mismatch(errFlag)
  );

endmodule

// File: rtl/rcc_round_checker_sva.sv
module rcc_round_checker_sva #(
  parameter int PIPE_CUBE = 1
)(
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [127:0] roundIn,
  input logic [127:0] roundKey,
  input logic [127:0] roundOut,
  input logic         chkValid,
  input logic         errFlag
);

  localparam int LAT = 2 + ((PIPE_CUBE != 0) ? 1 : 0);
  localparam int CW  = $clog2(LAT + 1);

  logic [CW-1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    sinceRst <= '0;
    else if (sinceRst != CW'(LAT)) sinceRst <= sinceRst + 1'b1;
  end

  // R1: outputs idle after a reset edge
  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (!chkValid && !errFlag));

  // R3 / R11: verdict pulse mirrors the sampling strobe LAT edges earlier
  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == CW'(LAT)) |-> (chkValid == $past(inValid, LAT)));

  // R8: flag only qualified by a verdict pulse
  p_flag_qualified_r8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> chkValid);

  // R7: an all-zero consistent sample must be judged clean
  p_zero_state_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (roundIn == '0) && (roundKey == '0) && (roundOut == '0))
      |-> ##LAT (chkValid && !errFlag));

endmodule

bind rcc_round_checker rcc_round_checker_sva #(.PIPE_CUBE(PIPE_CUBE)) u_sva (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .roundIn (roundIn),
  .roundKey(roundKey),
  .roundOut(roundOut),
  .chkValid(chkValid),
  .errFlag (errFlag)
);

// File: tb/sim_rcc_round_checker.sv
`timescale 1ns/1ps
module sim_rcc_round_checker;

  localparam int PIPE = 1;
  localparam int LAT  = 2 + PIPE;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] roundIn = '0;
  logic [127:0] roundKey = '0;
  logic [127:0] roundOut = '0;
  logic         chkValid;
  logic         errFlag;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  rcc_round_checker #(.PIPE_CUBE(PIPE)) u0 (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .roundIn (roundIn),
    .roundKey(roundKey),
    .roundOut(roundOut),
    .chkValid(chkValid),
    .errFlag (errFlag)
  );

  // ---------------- reference round model ----------------
  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] refSbox(input logic [7:0] a);
    logic [7:0] v, o, c;
    v = 8'h00;
    c = 8'h63;
    for (int y = 1; y < 256; y++)
      if (refMul(a, 8'(y)) == 8'h01) v = 8'(y);
    for (int b = 0; b < 8; b++)
      o[b] = v[b] ^ v[(b+4)%8] ^ v[(b+5)%8] ^ v[(b+6)%8] ^ v[(b+7)%8] ^ c[b];
    return o;
  endfunction

  function automatic logic [127:0] refRound(input logic [127:0] st, input logic [127:0] key);
    logic [7:0] s [4][4];
    logic [7:0] t [4][4];
    logic [7:0] a0, a1, a2, a3;
    logic [127:0] res;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        s[r][c] = refSbox(st[127-8*(4*c+r) -: 8]);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        t[r][c] = s[r][(c+r)%4];
    for (int c = 0; c < 4; c++) begin
      a0 = t[0][c]; a1 = t[1][c]; a2 = t[2][c]; a3 = t[3][c];
      s[0][c] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
      s[1][c] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
      s[2][c] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
      s[3][c] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
    end
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        res[127-8*(4*c+r) -: 8] = s[r][c] ^ key[127-8*(4*c+r) -: 8];
    return res;
  endfunction

  function automatic logic [127:0] genBlock(input int seed);
    logic [31:0] x;
    logic [127:0] v;
    x = 32'(seed) * 32'h9E37_79B9 + 32'h0000_1234;
    for (int w = 0; w < 4; w++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      v[32*w +: 32] = x;
    end
    return v;
  endfunction

  function automatic logic [127:0] bitMask(input int pos);
    logic [127:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction

  // ---------------- check helpers ----------------
  task automatic expectBit(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  // one isolated sample, verdict checked at its exact cycle
  task automatic applyOne(input string req, input logic [127:0] vIn, input logic [127:0] vKey,
                          input logic [127:0] vOut, input logic expErr);
    @(negedge clk);
    roundIn  = vIn;
    roundKey = vKey;
    roundOut = vOut;
    inValid  = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    repeat (LAT-2) @(negedge clk);
    expectBit("R3", "chkValid before verdict", chkValid, 1'b0);
    expectBit("R8", "errFlag before verdict", errFlag, 1'b0);
    @(negedge clk);
    expectBit("R3", "chkValid at verdict", chkValid, 1'b1);
    expectBit(req, "errFlag at verdict", errFlag, expErr);
    @(negedge clk);
    expectBit("R3", "chkValid after verdict", chkValid, 1'b0);
    expectBit("R8", "errFlag after verdict", errFlag, 1'b0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    expectBit("R1", "chkValid in reset", chkValid, 1'b0);
    expectBit("R1", "errFlag in reset", errFlag, 1'b0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    expectBit("R1", "chkValid after reset", chkValid, 1'b0);
    expectBit("R1", "errFlag after reset", errFlag, 1'b0);
  endtask

  task automatic t_clean();
    logic [127:0] i, k;
    for (int s = 1; s <= 4; s++) begin
      i = genBlock(s);
      k = genBlock(100 + s);
      applyOne("R2", i, k, refRound(i, k), 1'b0);
    end
  endtask

  task automatic t_zeroBytes();
    logic [127:0] i, k, m;
    m = 128'hFF00FFFF_00FFFF00_FFFF00FF_FF0000FF;
    applyOne("R7", '0, '0, refRound('0, '0), 1'b0);
    i = genBlock(7) & m;
    k = genBlock(8);
    applyOne("R7", i, k, refRound(i, k), 1'b0);
  endtask

  task automatic t_outFlip();
    logic [127:0] i, k, o;
    int pos [6] = '{0, 7, 45, 64, 100, 127};
    i = genBlock(21);
    k = genBlock(22);
    o = refRound(i, k);
    foreach (pos[p]) applyOne("R4", i, k, o ^ bitMask(pos[p]), 1'b1);
  endtask

  task automatic t_keyFlip();
    logic [127:0] i, k, o;
    i = genBlock(31);
    k = genBlock(32);
    o = refRound(i, k);
    applyOne("R5", i, k ^ bitMask(3), o, 1'b1);
    applyOne("R5", i, k ^ bitMask(90), o, 1'b1);
  endtask

  task automatic t_inFlip();
    logic [127:0] i, k, o;
    i = genBlock(41);
    k = genBlock(42);
    o = refRound(i, k);
    applyOne("R6", i ^ bitMask(12), k, o, 1'b1);
    applyOne("R6", i ^ bitMask(121), k, o, 1'b1);
  endtask

  task automatic t_cancelPair();
    logic [127:0] i, k, m;
    i = genBlock(51);
    k = genBlock(52);
    m = '0;
    m[127-8*(4*2+0) -: 8] = 8'h20;  // row 0, column 2
    m[127-8*(4*2+3) -: 8] = 8'h20;  // row 3, column 2
    applyOne("R10", i, k, refRound(i, k) ^ m, 1'b0);
  endtask

  task automatic t_stream();
    localparam int N = 4;
    logic [127:0] vi [N];
    logic [127:0] vk [N];
    logic [127:0] vo [N];
    logic         ve [N];
    for (int n = 0; n < N; n++) begin
      vi[n] = genBlock(60 + n);
      vk[n] = genBlock(70 + n);
      vo[n] = refRound(vi[n], vk[n]);
      ve[n] = n[0];
      if (ve[n]) vo[n] = vo[n] ^ bitMask(9 * n + 1);
    end
    for (int c = 0; c < N + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) begin
        expectBit("R9", "stream chkValid", chkValid, 1'b1);
        expectBit("R9", "stream errFlag", errFlag, ve[c-LAT]);
      end else begin
        expectBit("R9", "stream chkValid idle", chkValid, 1'b0);
      end
      if (c < N) begin
        roundIn  = vi[c];
        roundKey = vk[c];
        roundOut = vo[c];
        inValid  = 1'b1;
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    expectBit("R9", "stream drained", chkValid, 1'b0);
  endtask

  task automatic t_idle();
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      inValid  = 1'b0;
      roundIn  = genBlock(80 + c);
      roundKey = genBlock(90 + c);
      roundOut = genBlock(95 + c);
    end
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      expectBit("R11", "chkValid without sample", chkValid, 1'b0);
      expectBit("R11", "errFlag without sample", errFlag, 1'b0);
    end
  endtask

  initial begin
    t_reset();
    t_clean();
    t_zeroBytes();
    t_outFlip();
    t_keyFlip();
    t_inFlip();
    t_cancelPair();
    t_stream();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #500000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule